// File: doc/BRIEF.md
# Tick-Based Watchdog Timer

This block guards a system against software that stops responding. A prescaler turns the system clock into a 10 ms tick, and a down-counter loaded with a programmable timeout counts those ticks. The timeout is measured in ticks and can span the whole 32-bit range. If the counter runs out before the software feeds it, the block drives a system-reset pulse that lasts a fixed number of clocks. It then goes back to its default timeout and arms itself again.

The watchdog is armed from reset with a default timeout of 6000 ticks, which is 60 s. Software writes a new timeout through a load strobe. The new value is only held in the block until the next feed, and only that feed moves it into the counter. A feed issued while the held timeout is zero switches the watchdog off. A later feed with a nonzero timeout switches it back on. The status outputs show whether the watchdog is enabled and how many ticks remain.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, `wd_enabled` is 1, `remaining` equals DEFAULT_TIMEOUT (6000), `sys_rst` is 0, and the held timeout is DEFAULT_TIMEOUT.
- R2: While enabled, `remaining` drops by one every CLK_PER_TICK clock cycles. A feed restarts the prescaler, so the first decrement after a feed comes exactly CLK_PER_TICK cycles after the feed's clock edge.
- R3: A feed (`feed`=1 at a clock edge) while the held timeout is nonzero makes `remaining` equal to that timeout and `wd_enabled` equal to 1 after the edge. This also applies when the watchdog was disabled.
- R4: A feed while the held timeout is zero sets `wd_enabled` to 0 and `remaining` to 0. While disabled, `remaining` holds, no reset pulse is produced and a timeout load does not re-enable the watchdog.
- R5: A load (`tmo_load`=1) changes only the held timeout and leaves the running count untouched. The new value first reaches the counter at the next feed. A feed in the same cycle as a load uses the previously held value.
- R6: When a tick takes `remaining` from 1 to expiry with no feed in that cycle, `sys_rst` is 1 for exactly RST_PULSE_CYC cycles, starting right after that edge.
- R7: On expiry, the held timeout goes back to DEFAULT_TIMEOUT and `remaining` is reloaded with DEFAULT_TIMEOUT with `wd_enabled` kept at 1. A load in the expiry cycle is discarded.
- R8: A feed in the same cycle as expiry wins: the counter reloads and no reset pulse is produced.
- R9: The timeout is CNT_W (32) bits wide, so 0xFFFF_FFFF can be loaded and counts down normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_load | input | 1 | Strobe that captures `tmo_value` as the held timeout |
| tmo_value | input | CNT_W | New timeout in ticks |
| feed | input | 1 | Feed strobe: reloads the counter or disables the watchdog |
| wd_enabled | output | 1 | 1 while the watchdog is counting |
| remaining | output | CNT_W | Ticks left before expiry |
| sys_rst | output | 1 | System reset pulse, RST_PULSE_CYC cycles long |

## Verification
The hardest case to reach from the ports is a feed that lands on the exact edge where the last tick would expire the counter. The stimulus reaches it by feeding with a small timeout, counting clocks from that feed's edge using the prescaler restart rule, and raising `feed` so that it is sampled on the expiring edge. A second long case loads a new timeout in the middle of a countdown. It then lets the old count expire, which shows both that the load did not restart the count and that expiry discards the loaded value in favour of the default. The bench shortens the tick to a few clocks so that all of this fits in a short run.

// File: rtl/tick_watchdog_pkg.sv
`timescale 1ns/1ps
package tick_watchdog_pkg;

   // Action the countdown register takes in a given cycle
   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_FEED   = 2'd1,
      OP_DEC    = 2'd2,
      OP_EXPIRE = 2'd3
   } cnt_op_e;

   // Number of bits needed to hold values 0..n-1 (at least one)
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wd_tick_gen.sv
`timescale 1ns/1ps
module wd_tick_gen #(
   parameter int unsigned DIV = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   import tick_watchdog_pkg::*;

   generate
      if (DIV == 1) begin : g_passthru
         // Every clock is a tick; restart has nothing to realign
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int unsigned PW = idx_w(DIV);
         localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 phase <= '0;
            else if (restart || tick)   phase <= '0;
            else                        phase <= phase + 1'b1;
         end

         assign tick = (phase == PH_LAST);

         // R2: two ticks are never adjacent when the divider is above one
         a_r2_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
         // R2: a restart always leaves the phase at the start of a period
         a_r2_restart_phase : assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (phase == '0));
      end
   endgenerate

endmodule

// File: rtl/wd_countdown.sv
`timescale 1ns/1ps
module wd_countdown #(
   parameter int unsigned CNT_W           = 32,
   parameter int unsigned DEFAULT_TIMEOUT = 6000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             feed,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             enabled,
   output logic [CNT_W-1:0] remaining,
   output logic             expire
);
   import tick_watchdog_pkg::*;

   localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEFAULT_TIMEOUT);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] tmo_hold;
   logic [CNT_W-1:0] count_q;
   logic             en_q;
   cnt_op_e          op;

   // Feed has priority over everything, including a coincident expiry (R8)
   always_comb begin
      if (feed)                                   op = OP_FEED;
      else if (en_q && tick && count_q == ONE)    op = OP_EXPIRE;
      else if (en_q && tick)                      op = OP_DEC;
      else                                        op = OP_HOLD;
   end

   // Held timeout: expiry restores the default and drops a same-cycle load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tmo_hold <= DEF_CNT;
      else if (op == OP_EXPIRE)   tmo_hold <= DEF_CNT;
      else if (load)              tmo_hold <= load_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= DEF_CNT;
         en_q    <= 1'b1;
      end else begin
         unique case (op)
            OP_FEED: begin
               count_q <= tmo_hold;
               en_q    <= (tmo_hold != '0);
            end
            OP_EXPIRE: begin
               count_q <= DEF_CNT;
               en_q    <= 1'b1;
            end
            OP_DEC:  count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign enabled   = en_q;
   assign remaining = count_q;
   assign expire    = (op == OP_EXPIRE);

   // R1: a running watchdog never shows a zero count
   a_r1_live_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (count_q != '0));
   // R3: feed with a nonzero held timeout reloads and enables
   a_r3_feed_reload : assert property (@(posedge clk) disable iff (!rst_n)
      (feed && tmo_hold != '0) |=> (en_q && count_q == $past(tmo_hold)));
   // R4: feed with a zero held timeout disables
   a_r4_feed_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (feed && tmo_hold == '0) |=> (!en_q && count_q == '0));
   // R4: without a feed, a disabled watchdog stays disabled and frozen
   a_r4_idle_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !feed) |=> (!en_q && $stable(count_q)));
   // R2: a tick with no feed lowers a count above one by exactly one
   a_r2_decrement : assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && !feed && count_q > ONE) |=> (count_q == $past(count_q) - 1'b1));
   // R5: without tick or feed, the count does not move
   a_r5_count_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !feed) |=> $stable(count_q));
   // R7: expiry re-arms with the default in both count and held timeout
   a_r7_rearm : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (en_q && count_q == DEF_CNT && tmo_hold == DEF_CNT));
   // R5: a held timeout changes only through a load or an expiry
   a_r5_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expire) |=> $stable(tmo_hold));

endmodule

// File: rtl/wd_reset_pulse.sv
`timescale 1ns/1ps
module wd_reset_pulse #(
   parameter int unsigned LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_out
);
   import tick_watchdog_pkg::*;

   localparam int unsigned CW = idx_w(LEN + 1);
   localparam logic [CW-1:0] LEN_C = CW'(LEN);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left <= '0;
      else if (fire)           left <= LEN_C;
      else if (left != '0)     left <= left - 1'b1;
   end

   assign rst_out = (left != '0);

   // R6: an expiry event always drives the reset in the next cycle
   a_r6_pulse_start : assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rst_out);
   // R6: the pulse only starts from an expiry event
   a_r6_pulse_cause : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out) |-> $past(fire));

endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog #(
   parameter int unsigned CLK_PER_TICK    = 1_000_000,
   parameter int unsigned CNT_W           = 32,
   parameter int unsigned DEFAULT_TIMEOUT = 6000,
   parameter int unsigned RST_PULSE_CYC   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmo_load,
   input  logic [CNT_W-1:0] tmo_value,
   input  logic             feed,
   output logic             wd_enabled,
   output logic [CNT_W-1:0] remaining,
   output logic             sys_rst
);

   // Elaboration-time parameter checks
   generate
      if (CLK_PER_TICK < 1) begin : g_bad_div
         $error("tick_watchdog: CLK_PER_TICK must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tick_watchdog: CNT_W must be within 2..32");
      end
      if (DEFAULT_TIMEOUT == 0 ||
          64'(DEFAULT_TIMEOUT) > ((64'd1 << CNT_W) - 64'd1)) begin : g_bad_default
         $error("tick_watchdog: DEFAULT_TIMEOUT must be nonzero and fit in CNT_W bits");
      end
      if (RST_PULSE_CYC < 1) begin : g_bad_pulse
         $error("tick_watchdog: RST_PULSE_CYC must be at least 1");
      end
   endgenerate

   logic tick;
   logic expire;

   wd_tick_gen #(
      .DIV (CLK_PER_TICK)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (feed),
      .tick    (tick)
   );

   wd_countdown #(
      .CNT_W           (CNT_W),
      .DEFAULT_TIMEOUT (DEFAULT_TIMEOUT)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .feed      (feed),
      .load      (tmo_load),
      .load_val  (tmo_value),
      .enabled   (wd_enabled),
      .remaining (remaining),
      .expire    (expire)
   );

   wd_reset_pulse #(
      .LEN (RST_PULSE_CYC)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (expire),
      .rst_out (sys_rst)
   );

   // R8: a feed while no pulse is active can never start one
   a_r8_feed_blocks_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (feed && !sys_rst) |=> !sys_rst);
   // R4: no pulse can start while the watchdog is disabled
   a_r4_no_pulse_disabled : assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_enabled && !sys_rst) |=> !sys_rst);

endmodule

// File: tb/tick_watchdog_tb_top.sv
`timescale 1ns/1ps
module tick_watchdog_tb_top;

   localparam int unsigned DIV  = 4;
   localparam int unsigned W    = 32;
   localparam int unsigned DEF  = 6000;
   localparam int unsigned PLEN = 3;

   typedef struct {
      string       req;
      logic [W-1:0] rem;
      logic        en;
      logic        rst;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmo_load = 1'b0;
   logic [W-1:0]  tmo_value = '0;
   logic          feed = 1'b0;
   logic          wd_enabled;
   logic [W-1:0]  remaining;
   logic          sys_rst;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   tick_watchdog #(
      .CLK_PER_TICK    (DIV),
      .CNT_W           (W),
      .DEFAULT_TIMEOUT (DEF),
      .RST_PULSE_CYC   (PLEN)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmo_load   (tmo_load),
      .tmo_value  (tmo_value),
      .feed       (feed),
      .wd_enabled (wd_enabled),
      .remaining  (remaining),
      .sys_rst    (sys_rst)
   );

   // ---------------- driver tasks (act on falling edges) ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_feed();
      feed = 1'b1;
      @(negedge clk);
      feed = 1'b0;
   endtask

   task automatic do_load(input logic [W-1:0] v);
      tmo_load  = 1'b1;
      tmo_value = v;
      @(negedge clk);
      tmo_load  = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic [W-1:0] rem,
                             input logic en, input logic rst);
      exp_t e;
      e.req = req; e.rem = rem; e.en = en; e.rst = rst;
      sb_q.push_back(e);
   endtask

   // ---------------- monitor: pops and compares just after a falling edge ----
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (remaining !== e.rem || wd_enabled !== e.en || sys_rst !== e.rst) begin
               errors++;
               $display("FAIL %s: got rem=%0d en=%0b rst=%0b, expected rem=%0d en=%0b rst=%0b",
                        e.req, remaining, wd_enabled, sys_rst, e.rem, e.en, e.rst);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      cyc(3);
      rst_n = 1'b1;                       // released at a falling edge, k=0
      expect_out("R1 reset state", DEF, 1'b1, 1'b0);
      cyc(8);
      expect_out("R2 two ticks after reset", DEF - 2, 1'b1, 1'b0);
      do_load(32'd5);                     // k=9
      expect_out("R5 load leaves count alone", DEF - 2, 1'b1, 1'b0);
      do_feed();
      expect_out("R3 feed loads held timeout", 32'd5, 1'b1, 1'b0);
      cyc(3);
      expect_out("R2 no tick before period ends", 32'd5, 1'b1, 1'b0);
      cyc(1);
      expect_out("R2 first tick one period after feed", 32'd4, 1'b1, 1'b0);
      cyc(15);                            // k=19
      expect_out("R6 last tick before expiry", 32'd1, 1'b1, 1'b0);
      cyc(1);                             // k=20 expiry
      expect_out("R6 R7 expiry pulse and rearm", DEF, 1'b1, 1'b1);
      cyc(2);
      expect_out("R6 pulse still high at last cycle", DEF, 1'b1, 1'b1);
      cyc(1);
      expect_out("R6 pulse length ended", DEF, 1'b1, 1'b0);
      do_feed();
      expect_out("R7 default restored after expiry", DEF, 1'b1, 1'b0);

      // disable through a zero timeout
      do_load(32'd0);
      do_feed();
      expect_out("R4 zero feed disables", 32'd0, 1'b0, 1'b0);
      cyc(40);
      expect_out("R4 disabled stays idle", 32'd0, 1'b0, 1'b0);
      do_load(32'd3);
      expect_out("R4 load does not enable", 32'd0, 1'b0, 1'b0);
      do_feed();
      expect_out("R3 feed re-enables", 32'd3, 1'b1, 1'b0);

      // feed on the expiring edge
      cyc(11);
      expect_out("R8 one tick left", 32'd1, 1'b1, 1'b0);
      do_feed();                          // sampled on the expiring edge
      expect_out("R8 feed wins over expiry", 32'd3, 1'b1, 1'b0);
      cyc(2);
      expect_out("R8 no pulse after collision", 32'd3, 1'b1, 1'b0);

      // load mid-count then let the old count expire
      do_load(32'd10);                    // k=3 after the collision feed
      expect_out("R5 mid-count load no restart", 32'd3, 1'b1, 1'b0);
      cyc(2);
      expect_out("R5 count continues old value", 32'd2, 1'b1, 1'b0);
      cyc(7);                             // k=12 expiry
      expect_out("R6 expiry of old timeout", DEF, 1'b1, 1'b1);
      cyc(3);
      do_feed();
      expect_out("R7 loaded value replaced by default", DEF, 1'b1, 1'b0);

      // full-width timeout, load and feed in the same cycle
      tmo_load = 1'b1; tmo_value = 32'hFFFF_FFFF; feed = 1'b1;
      @(negedge clk);
      tmo_load = 1'b0; feed = 1'b0;
      expect_out("R5 same-cycle feed uses old value", DEF, 1'b1, 1'b0);
      do_feed();
      expect_out("R9 full width load", 32'hFFFF_FFFF, 1'b1, 1'b0);
      cyc(4);
      expect_out("R9 full width decrement", 32'hFFFF_FFFE, 1'b1, 1'b0);

      cyc(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- watchdog for the run itself ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL run watchdog: got hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule